// File: doc/BRIEF.md
# Line symbol aligner with signal-quality monitor

This block sits on the receive side of a short-reach cell physical layer whose line carries 5-bit block codes, each standing for a 4-bit data nibble. One line bit arrives per asserted `bit_en`, so the line bit rate is 5/4 of the data rate. A 32 Mbit/s line, for example, carries 25.6 Mbit/s of data. The block has no fixed rate of its own. When the line clock is doubled or quadrupled, `bit_en` simply fires more often; the coding does not change.

The block cuts the bit stream into 5-bit symbols. It finds the symbol boundary by testing each symbol against a build-time table of legal codes, so it can lock on idle fill as well as on cells. While hunting, every illegal symbol moves the boundary one bit later. A run of legal symbols confirms the alignment and raises `sig_good`. Too many illegal symbols inside a fixed window drop `sig_good` and restart the hunt. `sig_good` also gates the write enable of the downstream receive FIFO.

The escape code is always the first symbol of a two-symbol marker. While locked, the block flags a completed start-of-cell pair or timing-marker pair on the strobe of the pair's second symbol.

Top module: `symbol_aligner`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the hunt state. After reset `sig_good`, `sym_stb`, `mark_soc`, `mark_tmk` and `fifo_wr_en` are 0, and the next symbol boundary falls after the next 5 enabled bits.
- R2: Bits enter most-significant first: the earliest of the 5 bits becomes `sym_data[4]`. `sym_stb` pulses for one cycle, one clock after the edge that takes in the 5th enabled bit. Cycles with `bit_en` low change no symbol state.
- R3: `sym_ok` is 1 exactly when bit `sym_data` of `VALID_MASK` is set. In the default table, code 5'h00 is illegal and 5'h02, 5'h0D and 5'h15 are legal.
- R4: In the hunt or verify state, an illegal symbol moves the boundary one bit later, so the next symbol completes after 6 enabled bits instead of 5.
- R5: A legal symbol in hunt enters verify. `VERIFY_LEN` (16) consecutive legal symbols in verify enter lock, and `sig_good` rises with the strobe of the last of them. An illegal symbol in verify returns the block to hunt.
- R6: While locked, symbols are grouped in windows of `WIN_LEN` (64) counted from lock. The `BAD_LIMIT`-th (4th) illegal symbol inside one window drops `sig_good` with that symbol's strobe and returns to hunt. The illegal count clears at the end of each window, so 3 illegal symbols per window never drop lock.
- R7: `fifo_wr_en` equals `fifo_wr_req` AND `sig_good` in every cycle.
- R8: While locked, a symbol equal to `ESC_CODE` (default 5'h02) that is not itself the second symbol of a pair opens a pair. If the next symbol equals `SOC_CODE` (default 5'h02), `mark_soc` pulses with its strobe. If it equals `TMK_CODE` (default 5'h0D), `mark_tmk` pulses instead. Outside lock, no marker is flagged.
- R9: Idle cycles with `bit_en` low, inserted anywhere in the stream, do not change the symbols, flags or lock result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| fifo_wr_req | input | 1 | Write request toward the receive FIFO |
| sym_stb | output | 1 | One-cycle pulse when a symbol completes |
| sym_data | output | 5 | Last completed symbol, earliest bit in bit 4 |
| sym_ok | output | 1 | Last symbol is a legal code |
| mark_soc | output | 1 | Start-of-cell pair completed (with strobe) |
| mark_tmk | output | 1 | Timing-marker pair completed (with strobe) |
| sig_good | output | 1 | Alignment locked and signal healthy |
| fifo_wr_en | output | 1 | Gated FIFO write enable |

## Verification
The symbol outputs, the marker flags and `sig_good` all come from registers. Each becomes visible one clock after the edge that takes in the 5th enabled bit of a symbol. `fifo_wr_en` follows `fifo_wr_req` in the same cycle. The bench drives each bit on the falling edge and advances a reference model by that one bit. It then compares every output on the next falling edge, which is one rising edge later and is exactly when the registers show that bit's effect. The directed checks for slipping, lock gain, lock loss and markers are placed on the cycle after the bit that completes the relevant symbol.

// File: rtl/symal_pkg.sv
package symal_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;
endpackage

// File: rtl/symal_slicer.sv
module symal_slicer #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             slip,
  output logic             sym_done,
  output logic [SYM_W-1:0] sym_word
);
  localparam int CW = $clog2(SYM_W) + 1;

  logic [SYM_W-1:0] shreg;
  logic [CW-1:0]    cnt;

  assign sym_word = {shreg[SYM_W-2:0], bit_in};
  assign sym_done = bit_en && (cnt == CW'(SYM_W - 1));

  // Setting the counter to all ones makes it wrap through zero, which adds one bit to the next symbol.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (bit_en) begin
      shreg <= sym_word;
      if (sym_done) cnt <= slip ? '1 : '0;
      else          cnt <= cnt + 1'b1;
    end
  end

  // R4
  slip_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    slip |-> sym_done);

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(SYM_W)) || (cnt == '1));
endmodule

// File: rtl/symal_monitor.sv
module symal_monitor
  import symal_pkg::*;
#(
  parameter int VERIFY_LEN = 16,
  parameter int WIN_LEN    = 64,
  parameter int BAD_LIMIT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_done,
  input  logic sym_valid,
  output logic slip,
  output logic locked,
  output logic sig_good
);
  localparam int VW = (VERIFY_LEN > 1) ? $clog2(VERIFY_LEN) : 1;
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int BW = $clog2(BAD_LIMIT + 1);

  sync_state_e   state;
  logic [VW-1:0] vcnt;
  logic [WW-1:0] wcnt;
  logic [BW-1:0] bcnt;
  logic          good_q;
  logic          last_bad;

  assign last_bad = (bcnt == BW'(BAD_LIMIT - 1));
  assign locked   = (state == ST_LOCKED);
  assign sig_good = good_q;
  assign slip     = sym_done && !sym_valid && (!locked || last_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HUNT;
      vcnt   <= '0;
      wcnt   <= '0;
      bcnt   <= '0;
      good_q <= 1'b0;
    end else if (sym_done) begin
      unique case (state)
        ST_HUNT: begin
          if (sym_valid) begin
            state <= ST_VERIFY;
            vcnt  <= '0;
          end
        end
        ST_VERIFY: begin
          if (!sym_valid) begin
            state <= ST_HUNT;
          end else if (vcnt == VW'(VERIFY_LEN - 1)) begin
            state  <= ST_LOCKED;
            good_q <= 1'b1;
            wcnt   <= '0;
            bcnt   <= '0;
          end else begin
            vcnt <= vcnt + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (!sym_valid && last_bad) begin
            state  <= ST_HUNT;
            good_q <= 1'b0;
          end else if (wcnt == WW'(WIN_LEN - 1)) begin
            wcnt <= '0;
            bcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
            if (!sym_valid) bcnt <= bcnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R5
  lock_from_verify_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(good_q) |-> $past(state == ST_VERIFY));

  // R6
  drop_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(good_q) |-> $past(sym_done && !sym_valid));

  // R6
  bad_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bcnt < BW'(BAD_LIMIT));
endmodule

// File: rtl/symal_output.sv
module symal_output #(
  parameter int                     SYM_W      = 5,
  parameter logic [(1<<SYM_W)-1:0]  VALID_MASK = 32'hECEC_EE04,
  parameter logic [SYM_W-1:0]       ESC_CODE   = 5'h02,
  parameter logic [SYM_W-1:0]       SOC_CODE   = 5'h02,
  parameter logic [SYM_W-1:0]       TMK_CODE   = 5'h0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_done,
  input  logic [SYM_W-1:0] sym_word,
  input  logic             locked,
  output logic             sym_valid,
  output logic             sym_stb,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_ok,
  output logic             mark_soc,
  output logic             mark_tmk
);
  logic esc_pend;

  assign sym_valid = VALID_MASK[sym_word];

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_stb  <= 1'b0;
      sym_data <= '0;
      sym_ok   <= 1'b0;
      mark_soc <= 1'b0;
      mark_tmk <= 1'b0;
      esc_pend <= 1'b0;
    end else begin
      sym_stb <= sym_done;
      if (sym_done) begin
        sym_data <= sym_word;
        sym_ok   <= sym_valid;
        mark_soc <= locked && esc_pend && (sym_word == SOC_CODE);
        mark_tmk <= locked && esc_pend && (sym_word == TMK_CODE);
        esc_pend <= locked && !esc_pend && (sym_word == ESC_CODE);
      end else begin
        mark_soc <= 1'b0;
        mark_tmk <= 1'b0;
      end
    end
  end

  // R8
  mark_with_symbol_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_soc || mark_tmk) |-> (sym_stb && sym_ok));

  // R8
  mark_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_soc || mark_tmk) |-> $past(locked));
endmodule

// File: rtl/symbol_aligner.sv
module symbol_aligner #(
  parameter int                     SYM_W      = 5,
  parameter int                     VERIFY_LEN = 16,
  parameter int                     WIN_LEN    = 64,
  parameter int                     BAD_LIMIT  = 4,
  parameter logic [(1<<SYM_W)-1:0]  VALID_MASK = 32'hECEC_EE04,
  parameter logic [SYM_W-1:0]       ESC_CODE   = 5'h02,
  parameter logic [SYM_W-1:0]       SOC_CODE   = 5'h02,
  parameter logic [SYM_W-1:0]       TMK_CODE   = 5'h0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             fifo_wr_req,
  output logic             sym_stb,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_ok,
  output logic             mark_soc,
  output logic             mark_tmk,
  output logic             sig_good,
  output logic             fifo_wr_en
);
  logic             sym_done;
  logic [SYM_W-1:0] sym_word;
  logic             sym_valid;
  logic             slip;
  logic             locked;

  symal_slicer #(.SYM_W(SYM_W)) u_slicer (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .slip     (slip),
    .sym_done (sym_done),
    .sym_word (sym_word)
  );

  symal_output #(
    .SYM_W      (SYM_W),
    .VALID_MASK (VALID_MASK),
    .ESC_CODE   (ESC_CODE),
    .SOC_CODE   (SOC_CODE),
    .TMK_CODE   (TMK_CODE)
  ) u_output (
    .clk       (clk),
    .rst       (rst),
    .sym_done  (sym_done),
    .sym_word  (sym_word),
    .locked    (locked),
    .sym_valid (sym_valid),
    .sym_stb   (sym_stb),
    .sym_data  (sym_data),
    .sym_ok    (sym_ok),
    .mark_soc  (mark_soc),
    .mark_tmk  (mark_tmk)
  );

  symal_monitor #(
    .VERIFY_LEN (VERIFY_LEN),
    .WIN_LEN    (WIN_LEN),
    .BAD_LIMIT  (BAD_LIMIT)
  ) u_monitor (
    .clk       (clk),
    .rst       (rst),
    .sym_done  (sym_done),
    .sym_valid (sym_valid),
    .slip      (slip),
    .locked    (locked),
    .sig_good  (sig_good)
  );

  assign fifo_wr_en = fifo_wr_req & sig_good;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sig_good && !sym_stb && !mark_soc && !mark_tmk));

  // R2
  strobe_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    sym_stb |-> $past(bit_en));
endmodule

// File: tb/symbol_aligner_tb.sv
module symbol_aligner_tb;
  localparam logic [31:0] MASK = 32'hECEC_EE04;
  localparam logic [4:0]  ESC  = 5'h02;
  localparam logic [4:0]  SOC  = 5'h02;
  localparam logic [4:0]  TMK  = 5'h0D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, bit_in = 1'b0, fifo_wr_req = 1'b0;
  logic sym_stb, sym_ok, mark_soc, mark_tmk, sig_good, fifo_wr_en;
  logic [4:0] sym_data;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model state
  logic [4:0] m_sr;
  int m_cnt, m_st, m_v, m_w, m_b;
  bit m_pend;
  bit e_stb, e_ok, e_soc, e_tmk, e_good;
  logic [4:0] e_data;
  int gap_pct = 0;

  always #2 clk = ~clk;

  symbol_aligner #(.VALID_MASK(MASK), .ESC_CODE(ESC), .SOC_CODE(SOC), .TMK_CODE(TMK)) u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .fifo_wr_req(fifo_wr_req),
    .sym_stb(sym_stb), .sym_data(sym_data), .sym_ok(sym_ok), .mark_soc(mark_soc),
    .mark_tmk(mark_tmk), .sig_good(sig_good), .fifo_wr_en(fifo_wr_en));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sr = '0; m_cnt = 0; m_st = 0; m_v = 0; m_w = 0; m_b = 0; m_pend = 0;
    e_stb = 0; e_ok = 0; e_soc = 0; e_tmk = 0; e_good = 0; e_data = '0;
  endtask

  task automatic model_bit(input bit en, input bit b);
    logic [4:0] w;
    bit done, valid, lk, slip;
    e_stb = 0; e_soc = 0; e_tmk = 0;
    if (!en) return;
    w = {m_sr[3:0], b};
    m_sr = w;
    done = (m_cnt == 4);
    if (!done) begin m_cnt++; return; end
    valid = MASK[w];
    lk = (m_st == 2);
    e_stb = 1; e_data = w; e_ok = valid;
    e_soc = lk && m_pend && (w == SOC);
    e_tmk = lk && m_pend && (w == TMK);
    m_pend = lk && !m_pend && (w == ESC);
    slip = 0;
    case (m_st)
      0: if (valid) begin m_st = 1; m_v = 0; end else slip = 1;
      1: if (!valid) begin m_st = 0; slip = 1; end
         else if (m_v == 15) begin m_st = 2; m_w = 0; m_b = 0; end
         else m_v++;
      default: if (!valid && m_b == 3) begin m_st = 0; slip = 1; end
         else if (m_w == 63) begin m_w = 0; m_b = 0; end
         else begin m_w++; if (!valid) m_b++; end
    endcase
    e_good = (m_st == 2);
    m_cnt = slip ? -1 : 0;
  endtask

  // one clock: drive at falling edge, sample at the next falling edge
  task automatic step(input bit en, input bit b, input bit req);
    bit_en = en; bit_in = b; fifo_wr_req = req;
    model_bit(en, b);
    @(posedge clk);
    @(negedge clk);
    check("R2 sym_stb", sym_stb, e_stb);
    if (e_stb) begin
      check("R2 sym_data", sym_data, e_data);
      check("R3 sym_ok", sym_ok, e_ok);
    end
    check("R5 sig_good", sig_good, e_good);
    check("R7 fifo_wr_en", fifo_wr_en, req & e_good);
    check("R8 mark_soc", mark_soc, e_soc);
    check("R8 mark_tmk", mark_tmk, e_tmk);
  endtask

  task automatic send_sym(input logic [4:0] code);
    for (int i = 4; i >= 0; i--) begin
      while (($urandom % 100) < gap_pct) step(1'b0, 1'($urandom), 1'($urandom));
      step(1'b1, code[i], 1'($urandom));
    end
  endtask

  function automatic logic [4:0] rand_valid();
    logic [4:0] c;
    do c = 5'($urandom); while (!MASK[c]);
    return c;
  endfunction

  task automatic do_reset();
    rst = 1'b1; bit_en = 0; fifo_wr_req = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 sig_good", sig_good, 0);
    check("R1 sym_stb", sym_stb, 0);
    check("R1 marks", {mark_soc, mark_tmk}, 0);
    check("R1 fifo_wr_en", fifo_wr_en, 0);
  endtask

  initial begin
    #480000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seen;
    process::self().srandom(32'd1264);
    @(negedge clk);
    do_reset();

    // R1 and R4: the first boundary is after 5 bits, an illegal code slips one bit
    send_sym(5'h00);
    check("R1 first boundary", sym_stb, 1);
    check("R3 illegal zero", sym_ok, 0);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b0);
      check("R4 slipped boundary", sym_stb, (i == 5) ? 1 : 0);
    end

    // R5: lock on random legal codes after two misaligning bits
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      send_sym(rand_valid());
      if (sig_good) seen = 1;
    end
    check("R5 lock reached", seen, 1);

    // R8: marker pairs while locked
    send_sym(5'h15); send_sym(5'h15);
    send_sym(ESC); send_sym(SOC);
    check("R8 start-of-cell flagged", mark_soc, 1);
    send_sym(5'h15);
    send_sym(ESC); send_sym(TMK);
    check("R8 timing marker flagged", mark_tmk, 1);

    // R6: 3 illegal codes per window keep lock
    for (int k = 0; k < 3; k++) send_sym(5'h00);
    for (int k = 0; k < 70; k++) send_sym(rand_valid());
    for (int k = 0; k < 3; k++) send_sym(5'h00);
    check("R6 three per window keep lock", sig_good, 1);
    // R6: 8 illegal in a row put at least 4 in one window
    for (int k = 0; k < 8; k++) send_sym(5'h00);
    check("R6 lock dropped", sig_good, 0);
    step(1'b0, 1'b0, 1'b1);
    check("R7 write blocked on loss", fifo_wr_en, 0);

    // R8: no marker outside lock
    send_sym(ESC); send_sym(SOC);
    check("R8 no marker in hunt", mark_soc, 0);

    // R9: idle gaps between bits, then lock again and random traffic
    do_reset();
    gap_pct = 30;
    step(1'b1, 1'b0, 1'b0);
    seen = 0;
    for (int k = 0; k < 300; k++) begin
      send_sym(rand_valid());
      if (sig_good) seen = 1;
    end
    check("R9 lock with gaps", seen, 1);
    for (int k = 0; k < 1500; k++)
      send_sym((($urandom % 25) == 0) ? 5'h00 : rand_valid());

    // R1: reset in mid-stream
    gap_pct = 0;
    do_reset();
    send_sym(rand_valid());
    check("R1 good after reset", sig_good, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule